// File: doc/BRIEF.md
# Run Length Violation Detector

This block watches the parallel word stream of a serial receiver and flags any run of identical bits that lasts too long. Each clock it consumes one data word whose active width is picked by a two-bit width mode (8, 10, 16 or 20 bits). It walks the active bits in serial order, from the least significant bit (the earliest received) to the most significant. It counts consecutive equal bits, and the count carries from one word into the next. The run may be all zeros or all ones.

When the running count passes a programmable threshold, a violation flag is raised. A stretcher holds the flag high for at least two clock cycles. The threshold is clamped to a maximum that depends on the width mode: 128 bit periods for 8-bit words, 160 for 10-bit, 512 for 16-bit and 640 for 20-bit. A synchronous clear input, or any change of the width mode, empties the run tracker and drops the flag.

Two small state machines carry the behaviour:

- **Run tracker** (states RUN_EMPTY, RUN_ZEROS, RUN_ONES) holds the polarity of the current run. Its transitions are:
  - *start*: EMPTY to ZEROS or ONES on the first bit.
  - *extend*: the same state when the next bit matches.
  - *flip*: ZEROS to ONES or back when the next bit differs.
  - *flush*: any state to EMPTY on a clear.
- **Stretcher** (states STR_IDLE, STR_FIRST, STR_SECOND) shapes the flag. Its transitions are:
  - *fire*: any state to FIRST on a violation.
  - *age*: FIRST to SECOND.
  - *expire*: SECOND to IDLE.
  - *drop*: any state to IDLE on a clear.

Top module: `rlv_detector`

## Requirements
- R1: A violation is detected when the run count at any active bit is strictly greater than the effective threshold. A run equal to the threshold is not a violation. The count carries across word boundaries, and bits are taken LSB first.
- R2: The flag is registered. A violation found in the word consumed at clock edge k makes `violation` high after edge k and after edge k+1. Without a further violation or clear, it is low after edge k+2.
- R3: A violation found while the flag is already high restarts the full two-cycle hold from that word.
- R4: The width mode codes are 0 = 8 bits, 1 = 10 bits, 2 = 16 bits and 3 = 20 bits. The effective threshold is the smaller of `threshold` and the mode maximum: 128, 160, 512 and 640 respectively.
- R5: The run counter saturates instead of wrapping, so an endless run keeps `violation` high on every cycle.
- R6: In a cycle where `mode` differs from its value in the previous cycle, the word is discarded. The run tracker is emptied and `violation` is low after that edge.
- R7: While `sync_clr` is high, the word is discarded and the run tracker is emptied. `violation` is low after that edge, even if the discarded word would have violated.
- R8: Bits of `data_in` above the active width have no effect on run counting.
- R9: After reset, `violation` is low.
- R10: Runs of ones are detected the same way as runs of zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of run tracker and stretcher |
| mode | input | 2 | Width mode: 0 = 8, 1 = 10, 2 = 16, 3 = 20 bits |
| threshold | input | THR_W (10) | Run-length limit in bit periods |
| data_in | input | MAX_W (20) | Received word, bit 0 earliest |
| violation | output | 1 | Stretched run-length violation flag |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a fresh violation and the stretcher's expiry. The bench produces it by finishing one long run and starting a new violating run of the other polarity exactly one word later. The new run then arrives while the stretcher is in its second held cycle. The flag is judged by sampling it over the two following cycles, where a design that lets the expiry win would show a premature low.

The second pair is a clear and a violation. The bench feeds a word that would violate in the same cycle as `sync_clr`. It expects the flag to be low after that edge, and the next word to be counted from an empty tracker.

// File: rtl/rlv_pkg.sv
package rlv_pkg;

    typedef enum logic [1:0] {
        MODE_W8  = 2'd0,
        MODE_W10 = 2'd1,
        MODE_W16 = 2'd2,
        MODE_W20 = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        RUN_EMPTY = 2'd0,
        RUN_ZEROS = 2'd1,
        RUN_ONES  = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        STR_IDLE   = 2'd0,
        STR_FIRST  = 2'd1,
        STR_SECOND = 2'd2
    } str_state_e;

    localparam int WORD_W8   = 8;
    localparam int WORD_W10  = 10;
    localparam int WORD_W16  = 16;
    localparam int WORD_W20  = 20;

    localparam int LIMIT_W8  = 128;
    localparam int LIMIT_W10 = 160;
    localparam int LIMIT_W16 = 512;
    localparam int LIMIT_W20 = 640;

    function automatic int mode_width(input wmode_e m);
        case (m)
            MODE_W8:  return WORD_W8;
            MODE_W10: return WORD_W10;
            MODE_W16: return WORD_W16;
            default:  return WORD_W20;
        endcase
    endfunction

    function automatic int mode_limit(input wmode_e m);
        case (m)
            MODE_W8:  return LIMIT_W8;
            MODE_W10: return LIMIT_W10;
            MODE_W16: return LIMIT_W16;
            default:  return LIMIT_W20;
        endcase
    endfunction

endpackage

// File: rtl/rlv_thresh_clamp.sv
module rlv_thresh_clamp
    import rlv_pkg::*;
#(
    parameter int THR_W  = 10,
    parameter int CNT_W  = 11,
    parameter int WIDX_W = 5
) (
    input  wmode_e              mode,
    input  logic [THR_W-1:0]    thr_in,
    output logic [CNT_W-1:0]    thr_eff,
    output logic [WIDX_W-1:0]   width
);

    int req_thr;
    int lim;

    always_comb begin
        req_thr = int'(thr_in);
        lim     = mode_limit(mode);
        width   = WIDX_W'(mode_width(mode));
        if (req_thr > lim) begin
            thr_eff = CNT_W'(lim);
        end else begin
            thr_eff = CNT_W'(req_thr);
        end
    end

endmodule

// File: rtl/rlv_run_scan.sv
module rlv_run_scan
    import rlv_pkg::*;
#(
    parameter int MAX_W  = 20,
    parameter int CNT_W  = 11,
    parameter int WIDX_W = 5
) (
    input  logic [MAX_W-1:0]    word,
    input  logic [WIDX_W-1:0]   width,
    input  run_state_e          st_in,
    input  logic [CNT_W-1:0]    cnt_in,
    input  logic [CNT_W-1:0]    thr,
    output run_state_e          st_out,
    output logic [CNT_W-1:0]    cnt_out,
    output logic                hit
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    run_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             same;

    always_comb begin
        st   = st_in;
        cnt  = cnt_in;
        hit  = 1'b0;
        same = 1'b0;
        for (int i = 0; i < MAX_W; i++) begin
            if (i < int'(width)) begin
                same = (st == RUN_ONES  &&  word[i]) ||
                       (st == RUN_ZEROS && !word[i]);
                if (same) begin
                    if (cnt != CNT_SAT) begin
                        cnt = cnt + CNT_ONE;
                    end
                end else begin
                    cnt = CNT_ONE;
                    st  = word[i] ? RUN_ONES : RUN_ZEROS;
                end
                if (cnt > thr) begin
                    hit = 1'b1;
                end
            end
        end
        st_out  = st;
        cnt_out = cnt;
    end

endmodule

// File: rtl/rlv_run_track.sv
module rlv_run_track
    import rlv_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  run_state_e          st_next,
    input  logic [CNT_W-1:0]    cnt_next,
    output run_state_e          st_q,
    output logic [CNT_W-1:0]    cnt_q
);

    run_state_e       st_d;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RUN_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        if (flush) begin
            st_d  = RUN_EMPTY;
            cnt_d = '0;
        end else begin
            unique case (st_next)
                RUN_ZEROS, RUN_ONES: begin
                    st_d  = st_next;
                    cnt_d = cnt_next;
                end
                default: begin
                    st_d  = RUN_EMPTY;
                    cnt_d = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rlv_stretch.sv
module rlv_stretch
    import rlv_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    drop,
    input  logic    fire,
    output logic    flag
);

    str_state_e state_q;
    str_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (drop) begin
            state_d = STR_IDLE;
        end else if (fire) begin
            state_d = STR_FIRST;
        end else begin
            unique case (state_q)
                STR_FIRST:  state_d = STR_SECOND;
                STR_SECOND: state_d = STR_IDLE;
                default:    state_d = STR_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            STR_FIRST, STR_SECOND: flag = 1'b1;
            default:               flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/rlv_detector.sv
module rlv_detector
    import rlv_pkg::*;
#(
    parameter int MAX_W = 20,
    parameter int THR_W = 10,
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_clr,
    input  logic [1:0]          mode,
    input  logic [THR_W-1:0]    threshold,
    input  logic [MAX_W-1:0]    data_in,
    output logic                violation
);

    localparam int WIDX_W = $clog2(MAX_W + 1);

    wmode_e             mode_e;
    wmode_e             mode_q;
    logic               mode_chg;
    logic               clear;
    logic [CNT_W-1:0]   thr_eff;
    logic [WIDX_W-1:0]  width;
    run_state_e         run_st;
    run_state_e         scan_st;
    logic [CNT_W-1:0]   run_cnt;
    logic [CNT_W-1:0]   scan_cnt;
    logic               scan_hit;
    logic               hit_eff;

    assign mode_e = wmode_e'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_W8;
        end else begin
            mode_q <= mode_e;
        end
    end

    assign mode_chg = (mode_e != mode_q);
    assign clear    = sync_clr | mode_chg;
    assign hit_eff  = scan_hit & ~clear;

    rlv_thresh_clamp #(
        .THR_W  (THR_W),
        .CNT_W  (CNT_W),
        .WIDX_W (WIDX_W)
    ) u_clamp (
        .mode    (mode_e),
        .thr_in  (threshold),
        .thr_eff (thr_eff),
        .width   (width)
    );

    rlv_run_scan #(
        .MAX_W  (MAX_W),
        .CNT_W  (CNT_W),
        .WIDX_W (WIDX_W)
    ) u_scan (
        .word    (data_in),
        .width   (width),
        .st_in   (run_st),
        .cnt_in  (run_cnt),
        .thr     (thr_eff),
        .st_out  (scan_st),
        .cnt_out (scan_cnt),
        .hit     (scan_hit)
    );

    rlv_run_track #(
        .CNT_W (CNT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (clear),
        .st_next  (scan_st),
        .cnt_next (scan_cnt),
        .st_q     (run_st),
        .cnt_q    (run_cnt)
    );

    rlv_stretch u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (clear),
        .fire  (hit_eff),
        .flag  (violation)
    );

endmodule

// File: rtl/rlv_detector_chk.sv
module rlv_detector_chk
    import rlv_pkg::*;
#(
    parameter int MAX_W = 20,
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_clr,
    input  logic [1:0]          mode,
    input  logic                violation,
    input  logic                hit,
    input  logic [CNT_W-1:0]    thr_eff,
    input  logic [CNT_W-1:0]    run_cnt
);

    localparam logic [CNT_W-1:0] SAT = '1;

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd3;
        end else if (hit) begin
            age <= 2'd1;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> violation);

    assert_min_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(violation) && !sync_clr && mode == $past(mode)) |=> violation);

    assert_bounded_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (age == 2'd1 || age == 2'd2));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == SAT) |=> (run_cnt == SAT || int'(run_cnt) <= MAX_W));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> !violation);

    always_comb begin
        if (rst_n) begin
            assert_clamp_R4: assert (int'(thr_eff) <= mode_limit(wmode_e'(mode)))
                else $error("effective threshold above mode limit");
        end
    end

endmodule

bind rlv_detector rlv_detector_chk #(
    .MAX_W (MAX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .mode      (mode),
    .violation (violation),
    .hit       (hit_eff),
    .thr_eff   (thr_eff),
    .run_cnt   (run_cnt)
);

// File: tb/rlv_detector_tb.sv
module rlv_detector_tb;

    localparam int MAX_W = 20;
    localparam int THR_W = 10;
    localparam logic [MAX_W-1:0] ALT_A = 20'h55555; // bit0 = 1, top active bit = 0
    localparam logic [MAX_W-1:0] ALT_B = 20'hAAAAA; // bit0 = 0, top active bit = 1

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_clr = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [THR_W-1:0] threshold = 10'd10;
    logic [MAX_W-1:0] data_in = ALT_A;
    logic             violation;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rlv_detector u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_clr  (sync_clr),
        .mode      (mode),
        .threshold (threshold),
        .data_in   (data_in),
        .violation (violation)
    );

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (violation !== exp) begin
            n_fail++;
            $display("FAIL %s: violation=%0b expected %0b at %0t", req, violation, exp, $time);
        end
    endtask

    task automatic step(input logic [MAX_W-1:0] d, input logic exp, input string req);
        data_in = d;
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(1'b0, "R9 reset");
    endtask

    task automatic t_basic();
        mode = 2'd0; threshold = 10'd9;
        step(ALT_A, 1'b0, "R1 idle");
        step(20'h0, 1'b0, "R1 run equal threshold");
        step(ALT_A, 1'b0, "R1 break");
        threshold = 10'd8;
        step(20'h0, 1'b1, "R1 run above threshold");
        step(ALT_A, 1'b1, "R2 second held cycle");
        step(ALT_A, 1'b0, "R2 expiry");
        threshold = 10'd10;
        step(20'h0, 1'b0, "R1 partial run");
        step(20'h0, 1'b1, "R1 carry across words");
        step(ALT_A, 1'b1, "R2 hold");
        step(ALT_A, 1'b0, "R2 expiry");
    endtask

    task automatic t_ones();
        mode = 2'd0; threshold = 10'd8;
        step(ALT_A, 1'b0, "R10 idle");
        step(20'h000FF, 1'b0, "R10 ones equal threshold");
        step(ALT_B, 1'b0, "R10 break");
        threshold = 10'd7;
        step(ALT_A, 1'b0, "R10 idle");
        step(20'h000FF, 1'b1, "R10 ones above threshold");
        step(ALT_B, 1'b1, "R2 hold");
        step(ALT_B, 1'b0, "R2 expiry");
    endtask

    task automatic t_retrigger();
        mode = 2'd0; threshold = 10'd7;
        step(ALT_A, 1'b0, "R3 idle");
        step(20'h000FF, 1'b1, "R3 first event");
        step(ALT_B, 1'b1, "R3 second cycle");
        step(20'h0, 1'b1, "R3 event during second cycle");
        step(ALT_A, 1'b1, "R3 extended hold");
        step(ALT_A, 1'b0, "R3 expiry");
    endtask

    task automatic t_upper_ignored();
        mode = 2'd0; threshold = 10'd7;
        step(ALT_A, 1'b0, "R8 idle");
        step(20'hFFF55, 1'b0, "R8 upper ones ignored");
        step(20'h00055, 1'b0, "R8 upper zeros ignored");
    endtask

    task automatic t_mode_clear();
        mode = 2'd0; threshold = 10'd7;
        step(ALT_A, 1'b0, "R6 idle");
        step(20'h000FF, 1'b1, "R6 event");
        mode = 2'd1;
        step(ALT_A, 1'b0, "R6 mode change drops flag");
        threshold = 10'd10;
        step(ALT_A, 1'b0, "R6 idle");
        step(20'h003FF, 1'b0, "R6 ten ones equal threshold");
        mode = 2'd0;
        step(20'h000FF, 1'b0, "R6 word discarded on mode change");
        step(20'h000FF, 1'b0, "R6 run restarted");
        step(ALT_B, 1'b0, "R6 idle");
    endtask

    task automatic t_sync_clr();
        mode = 2'd0; threshold = 10'd7;
        step(ALT_A, 1'b0, "R7 idle");
        step(20'h000F0, 1'b0, "R7 short runs");
        sync_clr = 1'b1;
        step(20'h000FF, 1'b0, "R7 word discarded");
        sync_clr = 1'b0;
        step(20'h0000F, 1'b0, "R7 run restarted");
        step(ALT_A, 1'b0, "R7 idle");
        step(20'h000FF, 1'b1, "R7 event");
        sync_clr = 1'b1;
        step(20'h0, 1'b0, "R7 clear beats violation");
        sync_clr = 1'b0;
        step(ALT_A, 1'b0, "R7 idle after clear");
    endtask

    task automatic t_clamp(input logic [1:0] m, input int w, input int lim, input int total);
        int n_hit;
        n_hit = lim / w;
        mode = m; threshold = 10'd1023;
        step(ALT_A, 1'b0, "R4 mode set");
        step(ALT_A, 1'b0, "R4 idle");
        for (int n = 1; n <= total; n++) begin
            data_in = '0;
            @(posedge clk);
            @(negedge clk);
            if (n == n_hit - 1) check(1'b0, "R4 run at clamped limit");
            if (n == n_hit)     check(1'b1, "R4 run above clamped limit");
            if (n > n_hit)      check(1'b1, "R5 long run keeps flag");
        end
        step(ALT_A, 1'b1, "R2 hold");
        step(ALT_A, 1'b0, "R2 expiry");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ones();
        t_retrigger();
        t_upper_ignored();
        t_mode_clear();
        t_sync_clr();
        t_clamp(2'd0, 8, 128, 16);
        t_clamp(2'd1, 10, 160, 16);
        t_clamp(2'd2, 16, 512, 32);
        t_clamp(2'd3, 20, 640, 120);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule